// File: doc/BRIEF.md
# Idle-Gated Register Write Stall Unit

This unit sits on the register write path in front of an SD host controller core. Each write arrives on a valid/ready request channel and leaves on a valid/ready forward channel. A write to most addresses goes straight through. A write to a clock-control register, or to one of a group of command and transfer setup registers, is held until the core reports that its bus is idle. The core has a command-busy status and a clock-divider-ready status, and the unit knows the busy level of each.

While a write is held, the unit polls the chosen status once per poll interval. The interval is set by a cycle prescaler. If the status never shows idle within a fixed number of polls, the write is dropped and a sticky timeout flag is raised. Software clears the flag with a pulse.

Back-pressure works as follows. The unit holds one write at a time. `req_ready` is high only when that single buffer is empty. A write moves across when `req_valid` and `req_ready` are both high at a clock edge. Once a write is on the forward channel, `fwd_valid` stays high and `fwd_addr` and `fwd_data` stay unchanged until `fwd_ready` is seen high at an edge.

Top module: `wr_idle_gate`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `fwd_valid` is 0 and `err_timeout` is 0.
- R2: A write to any address outside 0x00–0x07 and other than 0x10 is offered on the forward channel in the cycle after it is accepted. Its address and data are unchanged, and both status inputs are ignored.
- R3: With `cfg_has_cmd_busy`=1, a write to the setup group (addresses 0x00–0x07) is held while `stat_cmd_busy` reads 1. It is released only by a poll that sees `stat_cmd_busy`=0, and `stat_clkdiv_ready` has no effect on it.
- R4: With `cfg_has_cmd_busy`=0, a write to the setup group is held while `stat_clkdiv_ready` reads 0. It is released by a poll that sees 1, and `stat_cmd_busy` has no effect on it.
- R5: A write to the clock-control address 0x10 always waits on `stat_clkdiv_ready`=1, whatever the value of `cfg_has_cmd_busy`.
- R6: The first poll of a held write happens at the first clock edge after it is accepted. Each later poll comes `cfg_prescale`+1 cycles after the one before it.
- R7: If MAX_POLLS polls in a row (default 1000) all see busy, the write is dropped and never forwarded. `err_timeout` rises and `req_ready` goes back to 1 in the cycle after the last poll.
- R8: `err_timeout` stays 1 until `err_clear` is seen high. It then reads 0 from the next cycle. If a new timeout happens in the same cycle as a clear, the flag stays set.
- R9: While a write is held or offered, `req_ready` is 0. An offered write keeps `fwd_valid`, `fwd_addr` and `fwd_data` stable until `fwd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming write is present |
| req_ready | output | 1 | Single buffer is empty |
| req_addr | input | 8 | Incoming register address |
| req_data | input | DW | Incoming write data |
| fwd_valid | output | 1 | Write offered to the core |
| fwd_ready | input | 1 | Core takes the offered write |
| fwd_addr | output | 8 | Forwarded address |
| fwd_data | output | DW | Forwarded data |
| stat_cmd_busy | input | 1 | Command-busy status, 1 = busy |
| stat_clkdiv_ready | input | 1 | Clock-divider-ready status, 0 = busy |
| cfg_has_cmd_busy | input | 1 | Command-busy status exists |
| cfg_prescale | input | PW | Poll interval minus one, in cycles |
| err_clear | input | 1 | Clears the timeout flag |
| err_timeout | output | 1 | Sticky poll-timeout flag |

## Verification
A wrong gate choice shows up at the first poll, one cycle after acceptance. The write is then released against the wrong status, or it stays stuck while the right status is idle. Poll-counter and prescaler faults move the moment of release or timeout by whole intervals. They show only at a release that lands just after a poll, or at the exact cycle the timeout flag rises, about 4000 cycles in. Buffer faults show on the very next forward handshake as a changed address or data, or as a write that was accepted and then lost.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int ADDR_W = 8;
  localparam int N_GRP  = 8;
  // setup-group addresses, lowest slot first
  localparam logic [N_GRP*ADDR_W-1:0] GRP_ADDRS =
    {8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01, 8'h00};
  localparam logic [ADDR_W-1:0] CLK_CTL_ADDR = 8'h10;

  typedef enum logic [1:0] {GATE_NONE, GATE_CMD, GATE_CLK} gate_e;
  typedef enum logic [1:0] {ST_EMPTY, ST_WAIT, ST_SEND} st_e;
endpackage

// File: rtl/wg_addr_class.sv
module wg_addr_class
  import wg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              has_cmd_busy,
  output gate_e             kind
);
  logic [N_GRP-1:0] hit;

  for (genvar i = 0; i < N_GRP; i++) begin : g_cmp
    assign hit[i] = (addr == GRP_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    if (|hit)                      kind = has_cmd_busy ? GATE_CMD : GATE_CLK;
    else if (addr == CLK_CTL_ADDR) kind = GATE_CLK;
    else                           kind = GATE_NONE;
  end
endmodule

// File: rtl/wg_poll_timer.sv
module wg_poll_timer #(
  parameter int PW        = 8,
  parameter int MAX_POLLS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic [PW-1:0] prescale,
  input  logic          busy,
  output logic          idle_hit,
  output logic          expired
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [PW-1:0] tick_q;
  logic [CW-1:0] polls_q;
  logic          poll_now;

  always_comb begin
    poll_now = active && (tick_q == '0);
    idle_hit = poll_now && !busy;
    expired  = poll_now && busy && (polls_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      polls_q <= '0;
    end else if (start) begin
      tick_q  <= '0;
      polls_q <= '0;
    end else if (poll_now) begin
      tick_q  <= prescale;
      polls_q <= polls_q + 1'b1;
    end else if (active) begin
      tick_q  <= tick_q - 1'b1;
    end
  end
endmodule

// File: rtl/wr_idle_gate.sv
module wr_idle_gate
  import wg_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PW        = 8,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DW-1:0]     fwd_data,
  input  logic              stat_cmd_busy,
  input  logic              stat_clkdiv_ready,
  input  logic              cfg_has_cmd_busy,
  input  logic [PW-1:0]     cfg_prescale,
  input  logic              err_clear,
  output logic              err_timeout
);
  st_e               st_q;
  gate_e             kind_in, kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              err_q, take, busy_sel, idle_hit, expired;

  wg_addr_class u_class (
    .addr(req_addr), .has_cmd_busy(cfg_has_cmd_busy), .kind(kind_in)
  );

  assign busy_sel = (kind_q == GATE_CMD) ? stat_cmd_busy : !stat_clkdiv_ready;
  assign take     = req_valid && (st_q == ST_EMPTY);

  wg_poll_timer #(.PW(PW), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(take), .active(st_q == ST_WAIT),
    .prescale(cfg_prescale), .busy(busy_sel),
    .idle_hit(idle_hit), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_EMPTY;
      kind_q <= GATE_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ST_EMPTY: if (take) begin
          addr_q <= req_addr;
          data_q <= req_data;
          kind_q <= kind_in;
          st_q   <= (kind_in == GATE_NONE) ? ST_SEND : ST_WAIT;
        end
        ST_WAIT: begin
          if (idle_hit)     st_q <= ST_SEND;
          else if (expired) st_q <= ST_EMPTY;
        end
        ST_SEND: if (fwd_ready) st_q <= ST_EMPTY;
        default: st_q <= ST_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (expired)   err_q <= 1'b1;
    else if (err_clear) err_q <= 1'b0;
  end

  assign req_ready   = (st_q == ST_EMPTY);
  assign fwd_valid   = (st_q == ST_SEND);
  assign fwd_addr    = addr_q;
  assign fwd_data    = data_q;
  assign err_timeout = err_q;
endmodule

// File: rtl/wr_idle_gate_chk.sv
module wr_idle_gate_chk
  import wg_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DW-1:0]     req_data,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [DW-1:0]     fwd_data,
  input logic              stat_cmd_busy,
  input logic              stat_clkdiv_ready,
  input logic              cfg_has_cmd_busy,
  input logic [PW-1:0]     cfg_prescale,
  input logic              err_clear,
  input logic              err_timeout
);
  logic in_grp;
  always_comb begin
    in_grp = 1'b0;
    for (int i = 0; i < N_GRP; i++)
      if (fwd_addr == GRP_ADDRS[i*ADDR_W +: ADDR_W]) in_grp = 1'b1;
  end

  // R1
  always @(posedge clk)
    if (!rst_n) r1_reset_idle_chk: assert (req_ready && !fwd_valid && !err_timeout);

  // R9
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && fwd_valid));
  // R9
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_data));
  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R3
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_valid) && in_grp && cfg_has_cmd_busy |-> !$past(stat_cmd_busy));
  // R5
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_valid) && fwd_addr == CLK_CTL_ADDR |-> $past(stat_clkdiv_ready));
  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> req_ready && !fwd_valid);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout && !err_clear |=> err_timeout);
endmodule

bind wr_idle_gate wr_idle_gate_chk #(.DW(DW), .PW(PW)) u_chk (.*);

// File: tb/wr_idle_gate_tb.sv
module wr_idle_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int PW = 8;
  localparam int NP = 1000;
  localparam int PS = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fwd_ready = 1, err_clear = 0;
  logic [7:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic stat_cmd_busy = 0, stat_clkdiv_ready = 1, cfg_has_cmd_busy = 1;
  logic [PW-1:0] cfg_prescale = PW'(PS);
  logic req_ready, fwd_valid, err_timeout;
  logic [7:0] fwd_addr;
  logic [DW-1:0] fwd_data;

  int n_chk = 0, n_bad = 0;
  logic [39:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_idle_gate #(.DW(DW), .PW(PW), .MAX_POLLS(NP)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each forward handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && fwd_valid && fwd_ready) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected forward", {fwd_addr, fwd_data}, 0);
      else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        check({fwd_addr, fwd_data} == e, "R2/R3/R4/R5 forwarded item", {fwd_addr, fwd_data}, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: returns one time unit after the accepting edge
  task automatic write(input logic [7:0] a, input logic [DW-1:0] d, input bit fwd);
    while (!req_ready) step();
    req_addr = a; req_data = d; req_valid = 1;
    if (fwd) exp_q.push_back({a, d});
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic hold_low(input int n, input string tag);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fwd_valid) ok = 0;
    end
    check(ok, tag, fwd_valid, 0);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3 * (PS + 1); i++) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !fwd_valid && !err_timeout, "R1 reset state",
          {req_ready, fwd_valid, err_timeout}, 3'b100);
    step(); rst_n = 1; step();

    // R2: ungated, statuses both busy
    stat_cmd_busy = 1; stat_clkdiv_ready = 0;
    write(8'h20, 32'hA5A5_0001, 1);
    @(negedge clk);
    check(fwd_valid && fwd_addr == 8'h20, "R2 one-cycle forward", fwd_valid, 1);
    drain("R2 drained");

    // R3: group via command-busy
    cfg_has_cmd_busy = 1; stat_cmd_busy = 1; stat_clkdiv_ready = 1;
    write(8'h00, 32'h1111_0000, 1);
    hold_low(20, "R3 held while cmd busy");
    stat_clkdiv_ready = 0;
    hold_low(10, "R3 clkdiv ignored");
    stat_cmd_busy = 0;
    drain("R3 released");
    stat_clkdiv_ready = 1;

    // R4: group via clock-divider-ready
    cfg_has_cmd_busy = 0; stat_cmd_busy = 0; stat_clkdiv_ready = 0;
    write(8'h05, 32'h2222_0005, 1);
    hold_low(10, "R4 held while divider not ready");
    stat_cmd_busy = 1;
    hold_low(10, "R4 cmd busy ignored");
    stat_clkdiv_ready = 1;
    drain("R4 released");
    stat_cmd_busy = 0;

    // R5: clock control ignores cfg and command-busy
    cfg_has_cmd_busy = 1; stat_cmd_busy = 1; stat_clkdiv_ready = 0;
    write(8'h10, 32'h3333_0010, 1);
    hold_low(10, "R5 held on divider");
    stat_clkdiv_ready = 1;
    drain("R5 released with cmd busy");
    stat_cmd_busy = 0;

    // R6: release lands between polls (polls at edges 1,5,9)
    stat_cmd_busy = 1;
    write(8'h01, 32'h4444_0001, 1);
    @(negedge clk); @(negedge clk);
    @(posedge clk); #1 stat_cmd_busy = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(!fwd_valid, "R6 no release before next poll", fwd_valid, 0);
    @(negedge clk);
    check(fwd_valid, "R6 release at next poll", fwd_valid, 1);
    drain("R6 drained");

    // R7: timeout drops write
    stat_cmd_busy = 1;
    write(8'h02, 32'h5555_0002, 0);
    begin
      bit ok = 1;
      for (int c = 1; c <= 2 + (NP - 1) * (PS + 1); c++) begin
        @(negedge clk);
        if (c < 2 + (NP - 1) * (PS + 1)) begin
          if (err_timeout || fwd_valid || req_ready) ok = 0;
        end else begin
          check(ok, "R7 held and no flag before last poll", err_timeout, 0);
          check(err_timeout, "R7 flag at timeout", err_timeout, 1);
          check(req_ready && !fwd_valid, "R7 dropped, buffer free",
                {req_ready, fwd_valid}, 2'b10);
        end
      end
    end
    stat_cmd_busy = 0;

    // R8: sticky, then cleared
    hold_low(10, "R7 never forwarded");
    check(err_timeout, "R8 flag sticky", err_timeout, 1);
    step(); err_clear = 1; step(); err_clear = 0;
    @(negedge clk);
    check(!err_timeout, "R8 flag cleared", err_timeout, 0);

    // R9: back-pressure
    fwd_ready = 0; step();
    write(8'h30, 32'h6666_0030, 1);
    begin
      bit ok = 1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (!fwd_valid || req_ready || fwd_addr != 8'h30 || fwd_data != 32'h6666_0030) ok = 0;
      end
      check(ok, "R9 held under back-pressure", fwd_valid, 1);
    end
    step(); fwd_ready = 1;
    drain("R9 released");

    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule